// File: doc/BRIEF.md
# Synchronized Switch Debouncer

This block turns the level from a mechanical switch, which may change at any moment with respect to the clock, into a clean level. The raw level first passes through a two-stage flip-flop synchronizer. A clean output then follows the synchronized level only after the two have disagreed on every clock for a programmable number of cycles. A disagreement that ends early, because the synchronized level returns to the clean value, discards the partial count, so bounce shorter than the threshold never reaches the output.

Optional strobes mark each accepted transition: one for a rise of the clean level and one for a fall, each lasting a single clock. A parameter removes them. The threshold is a parameter whose default of 250,000 cycles gives about 10 ms at 25 MHz. The counter width follows from it.

Top module: `sw_debounce`

## Requirements
- R1: A raw level held steady from a settled state reaches `clean_o` after exactly THRESH+2 rising clock edges, counting the edge that first samples it. Two of those edges are synchronizer latency.
- R2: THRESH defaults to 250,000 and must be at least 1. The run counter is ceil(log2(THRESH)) bits wide, with a minimum of 1, and never holds a value above THRESH-1.
- R3: While the synchronized level differs from `clean_o`, the run count rises by one per clock. On the THRESH-th consecutive differing clock, `clean_o` takes the synchronized level and the count returns to zero.
- R4: A clock on which the synchronized level equals `clean_o` clears the run count and leaves `clean_o` unchanged. A disagreement of THRESH-1 cycles therefore changes nothing, however often it repeats.
- R5: A bouncy press followed by a bouncy release, whose bounce pulses are all shorter than THRESH cycles, produces exactly two transitions on `clean_o`.
- R6: While `rst_ni` is low, both synchronizer stages, the run count, `clean_o`, `rise_o` and `fall_o` are 0. After reset, `clean_o` stays 0 until a high level has been stable for the threshold.
- R7: With EDGE_EN=1, `rise_o` is 1 for exactly one clock, in the clock after `clean_o` goes from 0 to 1.
- R8: With EDGE_EN=1, `fall_o` is 1 for exactly one clock, in the clock after `clean_o` goes from 1 to 0. `rise_o` and `fall_o` are never 1 together.
- R9: With EDGE_EN=0, `rise_o` and `fall_o` are always 0.
- R10: A small threshold such as 3 still follows R3. It passes bounce pulses of THRESH cycles or more to `clean_o` as extra transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state updates on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Switch level, asynchronous to `clk_i` |
| clean_o | output | 1 | Debounced level |
| rise_o | output | 1 | One-clock strobe after an accepted rise |
| fall_o | output | 1 | One-clock strobe after an accepted fall |

## Verification
The assertions watch the synchronized level rather than the raw pin, so they assume the synchronizer hands a settled 0 or 1 to the counter on every clock. They also assume reset is applied before the first edge that matters. In simulation a flip-flop cannot go metastable, so the bench keeps within that assumption by changing `raw_i` only on the falling clock edge. Bounce pulse widths are chosen against each threshold: every pulse is shorter than the larger threshold and at least as long as the small one. The same stimulus then shows bounce being rejected by one instance and passed by the other.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

   // Width needed to hold 0 .. th-1, never less than one bit
   function automatic int unsigned cnt_width(input int unsigned th);
      return (th <= 2) ? 1 : $clog2(th);
   endfunction

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbnc_timer.sv
module dbnc_timer #(
   parameter int unsigned THRESH = 250000,
   parameter int unsigned CNT_W  = 18
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sync_i,
   output logic             clean_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESH - 1);

   logic             clean_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         clean_q <= 1'b0;
         cnt_q   <= '0;
      end else if (sync_i != clean_q) begin
         if (cnt_q == LAST) begin
            clean_q <= sync_i;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         cnt_q <= '0;
      end
   end

   assign clean_o = clean_q;
   assign cnt_o   = cnt_q;

endmodule

// File: rtl/dbnc_edge.sv
module dbnc_edge #(
   parameter bit EDGE_EN = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic level_i,
   output logic rise_o,
   output logic fall_o
);

   if (EDGE_EN) begin : g_strobe
      logic prev_q, rise_q, fall_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            prev_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
         end else begin
            prev_q <= level_i;
            rise_q <= level_i & ~prev_q;
            fall_q <= ~level_i & prev_q;
         end
      end
      assign rise_o = rise_q;
      assign fall_o = fall_q;
   end else begin : g_nostrobe
      logic unused_w;
      assign unused_w = ^{clk_i, rst_ni, level_i};
      assign rise_o   = 1'b0;
      assign fall_o   = 1'b0;
   end

endmodule

// File: rtl/sw_debounce.sv
module sw_debounce #(
   parameter int unsigned THRESH      = 250000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EDGE_EN     = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic clean_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int unsigned CNT_W = dbnc_pkg::cnt_width(THRESH);

   if (THRESH < 1) begin : g_bad_thresh
      $error("sw_debounce: THRESH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sw_debounce: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
      $error("sw_debounce: derived counter width out of range");
   end

   logic             sync_w;
   logic [CNT_W-1:0] cnt_w;

   dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_i),
      .q_o   (sync_w)
   );

   dbnc_timer #(.THRESH(THRESH), .CNT_W(CNT_W)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync_w),
      .clean_o(clean_o),
      .cnt_o  (cnt_w)
   );

   dbnc_edge #(.EDGE_EN(EDGE_EN)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .level_i(clean_o),
      .rise_o (rise_o),
      .fall_o (fall_o)
   );

endmodule

// File: rtl/sw_debounce_chk.sv
module sw_debounce_chk #(
   parameter int unsigned THRESH  = 250000,
   parameter bit          EDGE_EN = 1'b1,
   parameter int unsigned CNT_W   = 18
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             sync_i,
   input logic             clean_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic             rise_i,
   input logic             fall_i
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESH - 1);

   // R2
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i <= LAST);

   // R4
   cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_i == clean_i) |=> (cnt_i == '0));

   // R4
   clean_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_i == clean_i) |=> $stable(clean_i));

   // R3
   run_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_i != clean_i && cnt_i != LAST) |=> ($stable(clean_i) && cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

   // R3
   accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_i != clean_i && cnt_i == LAST) |=> (clean_i == $past(sync_i) && cnt_i == '0));

   if (EDGE_EN) begin : g_edge_chk
      // R7
      rise_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(clean_i) |=> rise_i);
      // R7
      rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         rise_i |=> !rise_i);
      // R8
      fall_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(clean_i) |=> fall_i);
      // R8
      fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         fall_i |=> !fall_i);
      // R8
      strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !(rise_i && fall_i));
   end else begin : g_noedge_chk
      // R9
      strobe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!rise_i && !fall_i));
   end

endmodule

bind sw_debounce sw_debounce_chk #(
   .THRESH (THRESH),
   .EDGE_EN(EDGE_EN),
   .CNT_W  (CNT_W)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .sync_i (sync_w),
   .clean_i(clean_o),
   .cnt_i  (cnt_w),
   .rise_i (rise_o),
   .fall_i (fall_o)
);

// File: tb/sim_sw_debounce.sv
module sim_sw_debounce;

   localparam int TH_A = 8;
   localparam int TH_B = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic raw = 1'b0;
   logic clean_a, rise_a, fall_a;
   logic clean_b, rise_b, fall_b;

   always #2 clk = ~clk;

   sw_debounce #(.THRESH(TH_A), .EDGE_EN(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .raw_i(raw),
      .clean_o(clean_a), .rise_o(rise_a), .fall_o(fall_a));

   sw_debounce #(.THRESH(TH_B), .EDGE_EN(1'b0)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .raw_i(raw),
      .clean_o(clean_b), .rise_o(rise_b), .fall_o(fall_b));

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   // reference state, one set per instance
   bit dly_a[$] = '{1'b0, 1'b0};
   bit dly_b[$] = '{1'b0, 1'b0};
   int run_a = 0, run_b = 0;
   bit cl_a = 1'b0, pv_a = 1'b0, rs_a = 1'b0, fl_a = 1'b0;
   bit cl_b = 1'b0, pv_b = 1'b0, rs_b = 1'b0, fl_b = 1'b0;

   int trans_a = 0, trans_b = 0;
   logic last_a = 1'b0, last_b = 1'b0;

   task automatic model_step(input int th, ref bit dly[$], ref int run,
                             ref bit cl, ref bit pv, ref bit rs, ref bit fl,
                             input bit din);
      bit cur = dly[0];
      rs = cl & ~pv;
      fl = ~cl & pv;
      pv = cl;
      if (cur != cl) begin
         run++;
         if (run >= th) begin
            cl  = cur;
            run = 0;
         end
      end else begin
         run = 0;
      end
      void'(dly.pop_front());
      dly.push_back(din);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         dly_a = '{1'b0, 1'b0}; dly_b = '{1'b0, 1'b0};
         run_a = 0; run_b = 0;
         cl_a = 0; pv_a = 0; rs_a = 0; fl_a = 0;
         cl_b = 0; pv_b = 0; rs_b = 0; fl_b = 0;
      end else begin
         model_step(TH_A, dly_a, run_a, cl_a, pv_a, rs_a, fl_a, raw);
         model_step(TH_B, dly_b, run_b, cl_b, pv_b, rs_b, fl_b, raw);
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 u0 clean vs model", clean_a, cl_a);
         chk("R7 u0 rise vs model", rise_a, rs_a);
         chk("R8 u0 fall vs model", fall_a, fl_a);
         chk("R10 u1 clean vs model", clean_b, cl_b);
         chk("R9 u1 rise off", rise_b, 1'b0);
         chk("R9 u1 fall off", fall_b, 1'b0);
         if (clean_a !== last_a) trans_a++;
         if (clean_b !== last_b) trans_b++;
         last_a = clean_a;
         last_b = clean_b;
      end
   end

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles >= 200000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic hold(input logic v, input int n);
      raw = v;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R6: everything low under reset
      chk("R6 u0 clean in reset", clean_a, 1'b0);
      chk("R6 u0 rise in reset", rise_a, 1'b0);
      chk("R6 u0 fall in reset", fall_a, 1'b0);
      chk("R6 u1 clean in reset", clean_b, 1'b0);
      rst_n = 1'b1;
      hold(1'b0, 3 * TH_A);
      chk("R6 clean stays low after reset", clean_a, 1'b0);

      // R1: latency of a clean rise is TH_A+2 edges
      raw = 1'b1;
      repeat (TH_A + 1) @(negedge clk);
      chk("R1 clean still low one edge early", clean_a, 1'b0);
      @(negedge clk);
      chk("R1 clean high after THRESH+2 edges", clean_a, 1'b1);
      chk("R7 no rise in update cycle", rise_a, 1'b0);
      @(negedge clk);
      chk("R7 rise in following cycle", rise_a, 1'b1);
      @(negedge clk);
      chk("R7 rise lasts one cycle", rise_a, 1'b0);
      hold(1'b1, TH_A);

      // R4: repeated dips of THRESH-1 cycles change nothing
      for (int k = 0; k < 4; k++) begin
         hold(1'b0, TH_A - 1);
         hold(1'b1, 2);
      end
      hold(1'b1, 2 * TH_A);
      chk("R4 short dips rejected", clean_a, 1'b1);
      chk("R4 short dips no fall strobe", fall_a, 1'b0);

      // R8: clean fall and its strobe
      raw = 1'b0;
      repeat (TH_A + 2) @(negedge clk);
      chk("R8 clean low after THRESH+2 edges", clean_a, 1'b0);
      @(negedge clk);
      chk("R8 fall in following cycle", fall_a, 1'b1);
      @(negedge clk);
      chk("R8 fall lasts one cycle", fall_a, 1'b0);
      hold(1'b0, 2 * TH_A);

      // R5 / R10: bouncy press then bouncy release
      trans_a = 0;
      trans_b = 0;
      hold(1'b1, 4); hold(1'b0, 4); hold(1'b1, 5); hold(1'b0, 4);
      hold(1'b1, 6); hold(1'b0, 3);
      hold(1'b1, 4 * TH_A);
      chk("R5 pressed level accepted", clean_a, 1'b1);
      hold(1'b0, 4); hold(1'b1, 5); hold(1'b0, 4); hold(1'b1, 4);
      hold(1'b0, 6); hold(1'b1, 3);
      hold(1'b0, 4 * TH_A);
      chk("R5 released level accepted", clean_a, 1'b0);
      chk_int("R5 exactly two clean transitions", trans_a, 2);
      chk_int("R10 small threshold passes bounce", (trans_b > 2) ? 1 : 0, 1);
      chk("R10 small threshold settles low", clean_b, 1'b0);

      // R3: exact-threshold disagreement is accepted
      hold(1'b1, TH_A);
      hold(1'b0, 4 * TH_A);
      chk("R3 pulse of THRESH cycles is no longer bounce", (trans_a == 4) ? 1'b1 : 1'b0, 1'b1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule